// File: doc/BRIEF.md
# Serial stream pair selector

This block sits between ten serial link pairs and a switch core that has only four stream-pair ports. Each pair is one serial input pin and one serial output pin. Pairs 0 and 1 are wired to core ports 0 and 1 at all times. The other two core ports, called pick A and pick B, each take one pair chosen from the pool of pairs 2 to 9.

In selection mode the four connected pairs form a 128 x 128 channel non-blocking path at 2.048 Mb/s with a 4.096 MHz bit clock. The block routes each chosen input pin into its core port. It routes each core output back to the output pin of the same pair. It raises an output-enable bit for every output pin it drives, and the pad ring puts every other output pin into high impedance.

When the switch runs in any other configuration, the selector is bypassed: pairs 2 and 3 stand in for picks A and B. Register writes and mode changes are staged and take effect only on a frame boundary, so no frame is ever split between two sources.

Top module: `stream_pair_router`

## Requirements
- R1: After reset the block is in bypass. `pin_tx_oe` is 10'b00_0000_1111, core ports 0..3 carry pins 0..3, and output pins 0..3 carry core outputs 0..3.
- R2: Pairs 0 and 1 are always connected in both directions: `core_rx[0]=pin_rx[0]`, `core_rx[1]=pin_rx[1]`, `pin_tx[0]=core_tx[0]`, `pin_tx[1]=core_tx[1]`, and both enables are high.
- R3: In selection mode, `cfg_wdata[2:0]` is pick A's code and `cfg_wdata[5:3]` is pick B's code. A code c selects pair c+2. Core port 2 carries `pin_rx` of pair A and drives `pin_tx` of pair A. Core port 3 does the same for pair B.
- R4: The output-enable bit of every pair that is not connected is low, and its `pin_tx` is held at 1.
- R5: A write to the selection register, and a change of `pair_mode`, takes effect only at the clock edge where `frame_sync` is high. A write made in the same cycle as `frame_sync` waits for the next boundary.
- R6: If A and B select the same pair, B is ignored. `core_rx[3]` is 1 (idle), only pair A's output is enabled, and that output carries `core_tx[2]`.
- R7: When `pair_mode` is low at a boundary, picks A and B use pairs 2 and 3 whatever the register holds. The register keeps its value, and that value applies again once selection mode returns.
- R8: If several writes fall between two boundaries, only the last one is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | One-cycle pulse marking a frame boundary |
| pair_mode | input | 1 | 1 = stream-pair selection configuration, 0 = bypass |
| cfg_wr | input | 1 | Write strobe for the selection register |
| cfg_wdata | input | 6 | {code B, code A}, each 3 bits, pair = code + 2 |
| pin_rx | input | 10 | Serial input pin of each pair |
| pin_tx | output | 10 | Serial output pin of each pair |
| pin_tx_oe | output | 10 | Output enable per pair; low means the pad is released |
| core_rx | output | 4 | Serial inputs delivered to the core ports |
| core_tx | input | 4 | Serial outputs coming from the core ports |

## Verification
A wrong active selection shows at the ports as a misplaced or missing enable bit, and as a core input carrying the wrong pin. This is visible combinationally in the first cycle after the boundary that loaded it. A staging error, such as a pending value applied early or lost, shows as an enable pattern that changes on a cycle without `frame_sync`, or that stays stale after one. The bench therefore checks the full routing just before each boundary and again after it. A broken duplicate rule shows as three enables with a live `core_rx[3]`, or as two enables on a single pair's traffic.

// File: rtl/spr_pkg.sv
// Shared definitions for the stream pair router.
// Assumes: nothing beyond standard SystemVerilog.
package spr_pkg;

    // Level driven onto a serial line that carries no traffic.
    localparam logic IDLE_BIT = 1'b1;

    // Routing mode held by the active configuration.
    typedef enum logic {
        MODE_BYPASS = 1'b0,
        MODE_SELECT = 1'b1
    } route_mode_e;

endpackage

// File: rtl/spr_cfg_regs.sv
// Selection register with frame-aligned update.
// Writes land in a pending copy. The active copy (picks and mode) loads the
// pending copy only on a cycle with frame_sync high. A write in that same
// cycle stays pending until the following boundary.
// Assumes: frame_sync is synchronous to clk and lasts one cycle.
module spr_cfg_regs
    import spr_pkg::*;
#(
    parameter int PICKS = 2,
    parameter int SEL_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_sync,
    input  logic                   mode_req,
    input  logic                   cfg_wr,
    input  logic [PICKS*SEL_W-1:0] cfg_wdata,
    output logic [PICKS*SEL_W-1:0] act_sel,
    output route_mode_e            act_mode
);

    localparam int CFG_W = PICKS * SEL_W;

    // Reset code k for pick k, so selection mode starts on the bypass pairs.
    function automatic logic [CFG_W-1:0] reset_codes();
        logic [CFG_W-1:0] v;
        v = '0;
        for (int k = 0; k < PICKS; k++) begin
            v[k*SEL_W +: SEL_W] = SEL_W'(k);
        end
        return v;
    endfunction

    logic [CFG_W-1:0] pend_sel;

    // Capture software writes into the pending copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_sel <= reset_codes();
        end else if (cfg_wr) begin
            pend_sel <= cfg_wdata;
        end
    end

    // Move pending selection and requested mode into use at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sel  <= reset_codes();
            act_mode <= MODE_BYPASS;
        end else if (frame_sync) begin
            act_sel  <= pend_sel;
            act_mode <= route_mode_e'(mode_req);
        end
    end

endmodule

// File: rtl/spr_map.sv
// Turns the active selection into a pair index and a live flag per pick.
// In bypass, pick k uses pair FIXED+k. In selection mode it uses code+FIXED.
// A pick whose pair matches an earlier pick, or lies past the last pair, is
// not live: its core input idles and it drives no pin.
// Assumes: PICKS is small (the duplicate search is quadratic in PICKS).
module spr_map
    import spr_pkg::*;
#(
    parameter int NUM_PAIRS = 10,
    parameter int FIXED     = 2,
    parameter int PICKS     = 2,
    parameter int SEL_W     = 3,
    parameter int PAIR_W    = 4
) (
    input  logic [PICKS*SEL_W-1:0]         act_sel,
    input  route_mode_e                    act_mode,
    output logic [PICKS-1:0][PAIR_W-1:0]   pick_idx,
    output logic [PICKS-1:0]               pick_live
);

    // Resolve each pick to a pair and drop duplicates in favour of lower picks.
    always_comb begin
        for (int k = 0; k < PICKS; k++) begin
            int v;
            if (act_mode == MODE_SELECT) begin
                v = int'(act_sel[k*SEL_W +: SEL_W]) + FIXED;
            end else begin
                v = FIXED + k;
            end
            pick_live[k] = (v < NUM_PAIRS);
            pick_idx[k]  = PAIR_W'(v);
            for (int j = 0; j < k; j++) begin
                if (pick_live[j] && pick_idx[j] == pick_idx[k]) begin
                    pick_live[k] = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/spr_xbar.sv
// Serial crossbar between the pair pins and the core ports.
// Fixed pairs connect straight through. Each live pick connects its pair
// both ways. Every other output pin is disabled and held at the idle level.
// Assumes: live picks name distinct pairs at or above FIXED.
module spr_xbar
    import spr_pkg::*;
#(
    parameter int NUM_PAIRS = 10,
    parameter int FIXED     = 2,
    parameter int PICKS     = 2,
    parameter int PAIR_W    = 4
) (
    input  logic [NUM_PAIRS-1:0]           pin_rx,
    input  logic [FIXED+PICKS-1:0]         core_tx,
    input  logic [PICKS-1:0][PAIR_W-1:0]   pick_idx,
    input  logic [PICKS-1:0]               pick_live,
    output logic [FIXED+PICKS-1:0]         core_rx,
    output logic [NUM_PAIRS-1:0]           pin_tx,
    output logic [NUM_PAIRS-1:0]           pin_tx_oe
);

    // Inbound direction: pins into core ports.
    always_comb begin
        for (int f = 0; f < FIXED; f++) begin
            core_rx[f] = pin_rx[f];
        end
        for (int k = 0; k < PICKS; k++) begin
            core_rx[FIXED+k] = pick_live[k] ? pin_rx[pick_idx[k]] : IDLE_BIT;
        end
    end

    // Outbound direction: core ports onto pins, with enables.
    always_comb begin
        pin_tx    = {NUM_PAIRS{IDLE_BIT}};
        pin_tx_oe = '0;
        for (int f = 0; f < FIXED; f++) begin
            pin_tx[f]    = core_tx[f];
            pin_tx_oe[f] = 1'b1;
        end
        for (int k = 0; k < PICKS; k++) begin
            if (pick_live[k]) begin
                pin_tx[pick_idx[k]]    = core_tx[FIXED+k];
                pin_tx_oe[pick_idx[k]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/stream_pair_router.sv
// Top of the serial stream pair selector.
// Connects NUM_PAIRS serial pairs to a core with FIXED+PICKS ports. The first
// FIXED pairs are permanent. PICKS further ports are chosen at run time from
// the remaining pool, with frame-aligned updates.
// Assumes: frame_sync marks the first bit of each frame, one cycle wide.
module stream_pair_router
    import spr_pkg::*;
#(
    parameter int NUM_PAIRS   = 10,
    parameter int FIXED_PAIRS = 2,
    parameter int PICKS       = 2,
    localparam int SEL_W      = $clog2(NUM_PAIRS - FIXED_PAIRS),
    localparam int PAIR_W     = $clog2(NUM_PAIRS),
    localparam int CORE_W     = FIXED_PAIRS + PICKS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_sync,
    input  logic                   pair_mode,
    input  logic                   cfg_wr,
    input  logic [PICKS*SEL_W-1:0] cfg_wdata,
    input  logic [NUM_PAIRS-1:0]   pin_rx,
    output logic [NUM_PAIRS-1:0]   pin_tx,
    output logic [NUM_PAIRS-1:0]   pin_tx_oe,
    output logic [CORE_W-1:0]      core_rx,
    input  logic [CORE_W-1:0]      core_tx
);

    logic [PICKS*SEL_W-1:0]       act_sel;
    route_mode_e                  act_mode;
    logic [PICKS-1:0][PAIR_W-1:0] pick_idx;
    logic [PICKS-1:0]             pick_live;

    spr_cfg_regs #(.PICKS(PICKS), .SEL_W(SEL_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .mode_req   (pair_mode),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .act_sel    (act_sel),
        .act_mode   (act_mode)
    );

    spr_map #(
        .NUM_PAIRS (NUM_PAIRS),
        .FIXED     (FIXED_PAIRS),
        .PICKS     (PICKS),
        .SEL_W     (SEL_W),
        .PAIR_W    (PAIR_W)
    ) u_map (
        .act_sel   (act_sel),
        .act_mode  (act_mode),
        .pick_idx  (pick_idx),
        .pick_live (pick_live)
    );

    spr_xbar #(
        .NUM_PAIRS (NUM_PAIRS),
        .FIXED     (FIXED_PAIRS),
        .PICKS     (PICKS),
        .PAIR_W    (PAIR_W)
    ) u_xbar (
        .pin_rx    (pin_rx),
        .core_tx   (core_tx),
        .pick_idx  (pick_idx),
        .pick_live (pick_live),
        .core_rx   (core_rx),
        .pin_tx    (pin_tx),
        .pin_tx_oe (pin_tx_oe)
    );

endmodule

// File: rtl/stream_pair_router_chk.sv
// Port-level checker for stream_pair_router, attached by bind.
// Assumes: the duplicate-idle property applies when exactly two picks exist.
module stream_pair_router_chk #(
    parameter int NUM_PAIRS = 10,
    parameter int FIXED     = 2,
    parameter int PICKS     = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   frame_sync,
    input logic [NUM_PAIRS-1:0]   pin_rx,
    input logic [NUM_PAIRS-1:0]   pin_tx,
    input logic [NUM_PAIRS-1:0]   pin_tx_oe,
    input logic [FIXED+PICKS-1:0] core_rx
);

    localparam int CORE_W = FIXED + PICKS;

    // R2: permanent pairs pass input straight into the core.
    for (genvar f = 0; f < FIXED; f++) begin : g_fixed
        a_r2_fixed_inbound: assert property (@(posedge clk) disable iff (!rst_n)
            core_rx[f] == pin_rx[f]);
    end

    // R4: a released output pin sits at the idle level.
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_off
        a_r4_released_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_tx_oe[p] |-> pin_tx[p]);
    end

    // R5: the set of driven pins only changes across a frame boundary.
    a_r5_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> $stable(pin_tx_oe));

    // R6: between FIXED+1 and CORE_W pins are driven at all times.
    a_r6_enable_count: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pin_tx_oe) > FIXED) && ($countones(pin_tx_oe) <= CORE_W));

    // R6: a dropped pick leaves the last core input idle.
    if (PICKS == 2) begin : g_dup
        a_r6_dup_idle: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(pin_tx_oe) < CORE_W) |-> core_rx[CORE_W-1]);
    end

endmodule

bind stream_pair_router stream_pair_router_chk #(
    .NUM_PAIRS (NUM_PAIRS),
    .FIXED     (FIXED_PAIRS),
    .PICKS     (PICKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .pin_rx     (pin_rx),
    .pin_tx     (pin_tx),
    .pin_tx_oe  (pin_tx_oe),
    .core_rx    (core_rx)
);

// File: tb/sim_stream_pair_router.sv
// Directed bench for stream_pair_router: one task per scenario, each checking
// the full routing against a model kept from the requirements.
module sim_stream_pair_router;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic       pair_mode = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic [9:0] pin_rx = '0;
    logic [9:0] pin_tx;
    logic [9:0] pin_tx_oe;
    logic [3:0] core_rx;
    logic [3:0] core_tx = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the register: pending and active copies.
    int pend_a = 0, pend_b = 1;
    int act_a  = 0, act_b  = 1;
    bit act_md = 1'b0;

    stream_pair_router u0 (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .pair_mode(pair_mode),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .pin_rx(pin_rx), .pin_tx(pin_tx),
        .pin_tx_oe(pin_tx_oe), .core_rx(core_rx), .core_tx(core_tx)
    );

    always #10 clk = ~clk;

    task automatic check(string tag, string what, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Compare every output against the model under three data patterns.
    task automatic check_route(string tag);
        logic [9:0] rx_pat [3] = '{10'h2A5, 10'h15A, 10'h081};
        logic [3:0] tx_pat [3] = '{4'b0110, 4'b1001, 4'b0100};
        for (int i = 0; i < 3; i++) begin
            int pa, pb;
            bit dup;
            logic [9:0] e_oe, e_tx;
            logic [3:0] e_rx;
            pa  = act_md ? act_a + 2 : 2;
            pb  = act_md ? act_b + 2 : 3;
            dup = (pa == pb);
            @(negedge clk);
            pin_rx  = rx_pat[i];
            core_tx = tx_pat[i];
            #1;
            e_rx = {dup ? 1'b1 : rx_pat[i][pb], rx_pat[i][pa], rx_pat[i][1], rx_pat[i][0]};
            e_oe = 10'b11;
            e_oe[pa] = 1'b1;
            if (!dup) e_oe[pb] = 1'b1;
            e_tx = 10'h3FF;
            e_tx[0]  = tx_pat[i][0];
            e_tx[1]  = tx_pat[i][1];
            e_tx[pa] = tx_pat[i][2];
            if (!dup) e_tx[pb] = tx_pat[i][3];
            check(tag, "core_rx", {6'b0, core_rx}, {6'b0, e_rx});
            check(tag, "pin_tx_oe", pin_tx_oe, e_oe);
            check(tag, "pin_tx", pin_tx, e_tx);
        end
    endtask

    task automatic write_sel(int a, int b);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = {3'(b), 3'(a)};
        @(negedge clk);
        cfg_wr = 1'b0;
        pend_a = a;
        pend_b = b;
    endtask

    task automatic boundary(bit md);
        @(negedge clk);
        pair_mode  = md;
        frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
        act_a = pend_a;
        act_b = pend_b;
        act_md = md;
    endtask

    task automatic t_reset();
        check_route("R1");
    endtask

    task automatic t_select();
        write_sel(5, 0);
        boundary(1'b1);
        check_route("R3");
        write_sel(3, 6);
        boundary(1'b1);
        check_route("R2");
    endtask

    task automatic t_edges();
        write_sel(7, 0);
        boundary(1'b1);
        check_route("R3");
        write_sel(1, 7);
        boundary(1'b1);
        check_route("R4");
    endtask

    task automatic t_write_waits();
        int sa = act_a, sb = act_b;
        write_sel(4, 2);
        pair_mode = 1'b0;
        repeat (3) @(negedge clk);
        act_a = sa;
        act_b = sb;
        check_route("R5");
        boundary(1'b1);
        check_route("R5");
    endtask

    task automatic t_same_cycle();
        int oa = pend_a, ob = pend_b;
        @(negedge clk);
        pair_mode  = 1'b1;
        frame_sync = 1'b1;
        cfg_wr     = 1'b1;
        cfg_wdata  = {3'd5, 3'd6};
        @(negedge clk);
        frame_sync = 1'b0;
        cfg_wr     = 1'b0;
        act_a = oa;
        act_b = ob;
        act_md = 1'b1;
        pend_a = 6;
        pend_b = 5;
        check_route("R5");
        boundary(1'b1);
        check_route("R5");
    endtask

    task automatic t_duplicate();
        write_sel(3, 3);
        boundary(1'b1);
        check_route("R6");
        write_sel(0, 0);
        boundary(1'b1);
        check_route("R6");
    endtask

    task automatic t_bypass();
        write_sel(6, 4);
        boundary(1'b0);
        check_route("R7");
        boundary(1'b1);
        check_route("R7");
    endtask

    task automatic t_last_wins();
        write_sel(1, 2);
        write_sel(2, 5);
        write_sel(7, 4);
        boundary(1'b1);
        check_route("R8");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_edges();
        t_write_waits();
        t_same_cycle();
        t_duplicate();
        t_bypass();
        t_last_wins();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule